// File: doc/BRIEF.md
# Divider-Synchronous Injection Trigger Generator

This block times the charge injections that a synthesizer uses to cancel the periodic ripple on its oscillator control node. It runs on a fast clock. It watches the state count of the loop's feedback divider, which walks through `NDIV` distinct states in each reference period, and a one-cycle pulse that marks the start of each reference period. There are `NCH` independent channels. Each channel has a software-written target state, a fine-delay code, a charge-amplitude code and an enable. When the divider enters a channel's target state, the channel arms. It waits a number of extra fast-clock cycles set by the delay code. It then raises its injection-switch enable for a fixed number of cycles and presents its amplitude code for the length of that pulse.

All settings are copied into working registers only in the cycle that marks a reference boundary. Because of this, software can rewrite them at any time without splitting a period between old and new values. A channel fires at most once per period. A pulse never runs past the next boundary. A pulse that has not yet begun when the boundary arrives is dropped.

Top module: `inj_trigger_gen`

## Requirements
- R1: After reset, and until the first `ref_tick`, every `trig` bit is 0 and every `amp` field is 0.
- R2: With delay code 0, an enabled channel whose target state m is below `NDIV` raises `trig` exactly two cycles after the first cycle of the period in which `div_state` newly equals m. A newly entered state is one that differs from the previous cycle's value. The `ref_tick` cycle counts as a cycle of the new period.
- R3: A delay code d postpones the rise of `trig` by exactly d further cycles, so the rise comes 2+d cycles after the matching cycle.
- R4: A started pulse stays high for exactly `PW` consecutive cycles, unless R5 cuts it short.
- R5: `trig` is 0 in every cycle where `ref_tick` is 1. A pulse still running at a boundary ends there. A delayed pulse that has not started by the boundary never appears.
- R6: A channel produces at most one pulse per reference period, even if the divider enters the target state again within that period.
- R7: A channel whose enable bit was 0 at the period's `ref_tick` produces no pulse in that period.
- R8: A target state greater than or equal to `NDIV` makes the channel produce no pulse.
- R9: The enable, target, delay and amplitude values that govern a period are those present on the configuration inputs in that period's `ref_tick` cycle. Changes made at other times have no effect until the next boundary.
- R10: While a channel's `trig` is 1, its `amp` field carries the amplitude code captured for that period and holds steady. While `trig` is 0, the field is 0.
- R11: Channels are independent. The setting of one channel never changes the timing or amplitude of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | fast clock |
| rst | input | 1 | synchronous reset, active high |
| ref_tick | input | 1 | one-cycle mark of the first cycle of a reference period |
| div_state | input | SW | feedback divider state count |
| cfg_en | input | NCH | per-channel enable |
| cfg_match | input | NCH*SW | per-channel target state, channel i in bits i*SW upward |
| cfg_dly | input | NCH*DW | per-channel fine-delay code in fast-clock cycles |
| cfg_amp | input | NCH*AW | per-channel charge-amplitude code |
| trig | output | NCH | per-channel injection-switch enable |
| amp | output | NCH*AW | per-channel amplitude code, valid while trig is high |

## Verification
The bench targets several corner cases. A target of state 0 hits in the boundary cycle itself; a design that used the previous period's settings there would fire on stale values or miss the hit. A pulse that starts two cycles before a boundary must be cut to two cycles, and one delayed past the boundary must vanish; a design without truncation would leak a pulse into the next period. A divider pattern that revisits the target state mid-period exposes a design that fires twice. Settings changed in mid-period expose a design that applies registers immediately, because that design would fire in the same period instead of the next one.

// File: rtl/inj_trig_pkg.sv
package inj_trig_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_FIRE = 2'd2
    } chan_ph_e;

    function automatic logic below_limit(int unsigned v, int unsigned lim);
        return v < lim;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/inj_cfg_shadow.sv
module inj_cfg_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_tick,
    input  logic [W-1:0] cfg_in,
    output logic [W-1:0] cfg_eff
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst)           act_q <= '0;
        else if (ref_tick) act_q <= cfg_in;
    end

    // the boundary cycle already belongs to the new period
    assign cfg_eff = ref_tick ? cfg_in : act_q;
endmodule

// File: rtl/inj_state_edge.sv
module inj_state_edge #(
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] div_state,
    output logic          state_new
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [SW-1:0] prev_q;
    logic          prev_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            prev_vld <= 1'b0;
        end else begin
            prev_q   <= div_state;
            prev_vld <= 1'b1;
        end
    end

    assign state_new = !prev_vld || (div_state != prev_q);
endmodule

// File: rtl/inj_chan.sv
module inj_chan
    import inj_trig_pkg::*;
#(
    parameter int SW   = 6,
    parameter int DW   = 4,
    parameter int AW   = 5,
    parameter int NDIV = 40,
    parameter int PW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_tick,
    input  logic          state_new,
    input  logic [SW-1:0] div_state,
    input  logic          en,
    input  logic [SW-1:0] match,
    input  logic [DW-1:0] dly,
    input  logic [AW-1:0] amp_code,
    output logic          trig,
    output logic [AW-1:0] amp
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PCW = $clog2(PW + 1);
    localparam int CW  = int'(max2(DW, PCW));

    chan_ph_e      ph_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] amp_q;
    logic          fired_q;
    logic          hit;
    logic          fired_now;

    assign fired_now = fired_q && !ref_tick;
    assign hit = en && below_limit(32'(match), NDIV) && state_new
              && (div_state == match) && !fired_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            cnt_q   <= '0;
            amp_q   <= '0;
            fired_q <= 1'b0;
        end else begin
            fired_q <= hit | fired_now;
            if (hit) begin
                ph_q  <= PH_WAIT;
                cnt_q <= CW'(dly);
                amp_q <= amp_code;
            end else if (ref_tick) begin
                ph_q <= PH_IDLE;
            end else begin
                unique case (ph_q)
                    PH_WAIT: begin
                        if (cnt_q == '0) begin
                            ph_q  <= PH_FIRE;
                            cnt_q <= CW'(PW - 1);
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    PH_FIRE: begin
                        if (cnt_q == '0) ph_q <= PH_IDLE;
                        else             cnt_q <= cnt_q - 1'b1;
                    end
                    default: ph_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign trig = (ph_q == PH_FIRE) && !ref_tick;
    assign amp  = trig ? amp_q : '0;

    // checker state: pulse seen this period, length of current high run
    logic           seen_q;
    logic [PCW:0]   run_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            run_q  <= '0;
        end else begin
            if (ref_tick)  seen_q <= 1'b0;
            else if (trig) seen_q <= 1'b1;
            run_q <= trig ? run_q + 1'b1 : '0;
        end
    end

    p_single_fire_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(trig) |-> !seen_q);
    p_width_limit_r4: assert property (@(posedge clk) disable iff (rst)
        trig |-> (32'(run_q) < PW));
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !en |-> !trig);
    p_bad_match_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !below_limit(32'(match), NDIV) |-> !trig);
    p_amp_steady_r10: assert property (@(posedge clk) disable iff (rst)
        (trig && $past(trig)) |-> $stable(amp));
    p_boundary_low_r5: assert property (@(posedge clk) disable iff (rst)
        ref_tick |-> (amp == '0));
endmodule

// File: rtl/inj_trigger_gen.sv
module inj_trigger_gen #(
    parameter int NCH  = 4,
    parameter int SW   = 6,
    parameter int NDIV = 40,
    parameter int DW   = 4,
    parameter int AW   = 5,
    parameter int PW   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic [SW-1:0]     div_state,
    input  logic [NCH-1:0]    cfg_en,
    input  logic [NCH*SW-1:0] cfg_match,
    input  logic [NCH*DW-1:0] cfg_dly,
    input  logic [NCH*AW-1:0] cfg_amp,
    output logic [NCH-1:0]    trig,
    output logic [NCH*AW-1:0] amp
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CHW  = 1 + SW + DW + AW;
    localparam int CFGW = NCH * CHW;

    logic [CFGW-1:0] cfg_pack;
    logic [CFGW-1:0] cfg_eff;
    logic            state_new;

    inj_state_edge #(.SW(SW)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .div_state (div_state),
        .state_new (state_new)
    );

    inj_cfg_shadow #(.W(CFGW)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .cfg_in   (cfg_pack),
        .cfg_eff  (cfg_eff)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int B = c * CHW;
        assign cfg_pack[B +: CHW] = {cfg_en[c], cfg_match[c*SW +: SW],
                                     cfg_dly[c*DW +: DW], cfg_amp[c*AW +: AW]};

        inj_chan #(
            .SW(SW), .DW(DW), .AW(AW), .NDIV(NDIV), .PW(PW)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .ref_tick  (ref_tick),
            .state_new (state_new),
            .div_state (div_state),
            .en        (cfg_eff[B + CHW - 1]),
            .match     (cfg_eff[B + DW + AW +: SW]),
            .dly       (cfg_eff[B + AW +: DW]),
            .amp_code  (cfg_eff[B +: AW]),
            .trig      (trig[c]),
            .amp       (amp[c*AW +: AW])
        );
    end
endmodule

// File: tb/inj_trigger_gen_bench.sv
module inj_trigger_gen_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH = 4, SW = 6, NDIV = 40, DW = 4, AW = 5, PW = 3;
    localparam int SC = 2;
    localparam int P  = NDIV * SC;

    logic clk = 1'b0, rst = 1'b1, ref_tick = 1'b0;
    logic [SW-1:0] div_state = '0;
    logic          b_en[NCH];
    logic [SW-1:0] b_m[NCH];
    logic [DW-1:0] b_d[NCH];
    logic [AW-1:0] b_a[NCH];
    logic [NCH-1:0]    cfg_en;
    logic [NCH*SW-1:0] cfg_match;
    logic [NCH*DW-1:0] cfg_dly;
    logic [NCH*AW-1:0] cfg_amp;
    logic [NCH-1:0]    trig;
    logic [NCH*AW-1:0] amp;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // captured settings of the running period and its divider pattern
    int e_en[NCH], e_m[NCH], e_d[NCH], e_a[NCH];
    int st[P];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cfg_en[i]              = b_en[i];
            cfg_match[i*SW +: SW]  = b_m[i];
            cfg_dly[i*DW +: DW]    = b_d[i];
            cfg_amp[i*AW +: AW]    = b_a[i];
        end
    end

    inj_trigger_gen #(.NCH(NCH), .SW(SW), .NDIV(NDIV), .DW(DW), .AW(AW), .PW(PW))
    u_inj_trigger_gen (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .div_state(div_state),
        .cfg_en(cfg_en), .cfg_match(cfg_match), .cfg_dly(cfg_dly),
        .cfg_amp(cfg_amp), .trig(trig), .amp(amp)
    );

    function automatic int first_hit(int m);
        for (int o = 0; o < P; o++)
            if (st[o] == m && (o == 0 || st[o-1] != st[o])) return o;
        return -1;
    endfunction

    function automatic int start_of(int ch);
        int h;
        if (e_en[ch] == 0 || e_m[ch] >= NDIV) return -1;
        h = first_hit(e_m[ch]);
        if (h < 0) return -1;
        return h + 2 + e_d[ch];
    endfunction

    function automatic bit exp_trig(int ch, int o);
        int s;
        s = start_of(ch);
        return (s >= 0) && (o >= s) && (o < s + PW) && (o < P);
    endfunction

    function automatic string req_tag(int ch, int o, bit et);
        int s;
        s = start_of(ch);
        if (e_en[ch] == 0) return "R7";
        if (e_m[ch] >= NDIV) return "R8";
        if (o == 0) return "R5";
        if (s >= P - PW + 1 && o >= s) return "R5";
        if (!et && s >= 0 && o >= s + PW) return "R4";
        if (e_d[ch] != 0) return "R3";
        return "R2";
    endfunction

    task automatic check_cycle(int o);
        for (int ch = 0; ch < NCH; ch++) begin
            bit et;
            int ea;
            et = exp_trig(ch, o);
            ea = et ? e_a[ch] : 0;
            checks++;
            if (trig[ch] !== et) begin
                errors++;
                $display("FAIL %s ch%0d off%0d trig act %b exp %b",
                         req_tag(ch, o, et), ch, o, trig[ch], et);
            end
            checks++;
            if (int'(amp[ch*AW +: AW]) != ea) begin
                errors++;
                $display("FAIL R10 ch%0d off%0d amp act %0d exp %0d",
                         ch, o, amp[ch*AW +: AW], ea);
            end
        end
    endtask

    task automatic rand_cfg();
        for (int ch = 0; ch < NCH; ch++) begin
            b_en[ch] = ($urandom_range(0, 3) != 0);
            b_m[ch]  = SW'($urandom_range(0, NDIV + 6));
            b_d[ch]  = DW'($urandom_range(0, (1 << DW) - 1));
            b_a[ch]  = AW'($urandom_range(1, (1 << AW) - 1));
        end
    endtask

    // mode 0: random change at offset mc; mode 1: directed change for R9
    task automatic run_period(bit revisit, int mc, int mode);
        for (int o = 0; o < P; o++) st[o] = o / SC;
        if (revisit)
            for (int o = P/2; o < P/2 + 4; o++) st[o] = int'(b_m[0]);
        for (int ch = 0; ch < NCH; ch++) begin
            e_en[ch] = int'(b_en[ch]); e_m[ch] = int'(b_m[ch]);
            e_d[ch]  = int'(b_d[ch]);  e_a[ch] = int'(b_a[ch]);
        end
        for (int o = 0; o < P; o++) begin
            @(posedge clk);
            #1;
            div_state = SW'(st[o]);
            ref_tick  = (o == 0);
            if (o == mc) begin
                if (mode == 1) begin
                    b_en[3] = 1'b1; b_m[3] = SW'(20); b_d[3] = '0; b_a[3] = AW'(9);
                    b_m[0]  = SW'(NDIV + 2);
                end else begin
                    rand_cfg();
                end
            end
            #2;
            check_cycle(o);
        end
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd2024);
        for (int ch = 0; ch < NCH; ch++) begin
            b_en[ch] = 1'b1; b_m[ch] = SW'(ch); b_d[ch] = '0; b_a[ch] = AW'(5);
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: settings enabled on the inputs, but no boundary seen yet
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            #1 div_state = SW'(1 + (i % 3));
            #2;
            for (int ch = 0; ch < NCH; ch++) begin
                checks++;
                if (trig[ch] !== 1'b0 || amp[ch*AW +: AW] !== '0) begin
                    errors++;
                    $display("FAIL R1 ch%0d trig act %b exp 0 amp act %0d exp 0",
                             ch, trig[ch], amp[ch*AW +: AW]);
                end
            end
        end
        // state 0 hit in boundary cycle, late pulse truncated, late delay dropped, disabled
        b_en[0] = 1'b1; b_m[0] = SW'(0);        b_d[0] = '0;      b_a[0] = AW'(7);
        b_en[1] = 1'b1; b_m[1] = SW'(NDIV - 2); b_d[1] = '0;      b_a[1] = AW'(11);
        b_en[2] = 1'b1; b_m[2] = SW'(NDIV - 1); b_d[2] = DW'(15); b_a[2] = AW'(3);
        b_en[3] = 1'b0; b_m[3] = SW'(3);        b_d[3] = '0;      b_a[3] = AW'(4);
        run_period(1'b0, 10, 1);   // R5 R7, and R9 change in mid-period
        run_period(1'b0, -1, 0);   // R9 change now live, R8 invalid target on ch0
        // R6: divider revisits ch0 target in mid-period
        b_m[0] = SW'(5); b_d[0] = DW'(2);
        run_period(1'b1, -1, 0);
        // R11 and general timing under random settings
        for (int n = 0; n < 60; n++)
            run_period(($urandom_range(0, 4) == 0), int'($urandom_range(1, P - 1)), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired act running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule